// File: doc/BRIEF.md
# Two-Queue Conversion Scheduler with Preemption

This block decides which of two command queues feeds a shared analog-to-digital converter next. Both queues live in one 64-entry command table. Each queue has its own trigger pulse, start pointer, status code and sticky overrun flag. Queue 1 always wins. A queue 1 trigger that arrives while queue 2 owns the converter cancels the queue 2 conversion in progress, and queue 2 is parked as suspended. A queue 2 trigger that cannot be served yet is held as pending. Any surplus trigger is recorded as an overrun.

The scheduler fetches command words through a combinational table read port. It hands one conversion at a time to the converter over a valid/ready request channel. While `conv_valid` is high and `conv_ready` is low, the request holds still, so the converter may stall the scheduler for as long as it needs. The converter returns each result as a single-cycle `res_valid` pulse, and this pulse cannot be back-pressured. The scheduler forwards the result as a write strobe whose slot index equals the table index of the command that produced it.

A command word is `{pause, channel[5:0]}`. Status codes are 0 idle, 1 active, 2 pending, 3 suspended and 4 paused.

Top module: `dualq_sched`

## Requirements
- R1: After reset, both status codes are 0 (idle), both overrun flags are 0, and `conv_valid`, `conv_abort` and `res_wr` are 0.
- R2: An active queue converts its table entries in ascending index order, starting from its pointer. Each command's channel is taken from bits [5:0] of its word. Each result is written with `res_idx` equal to that command's table index and `res_data` equal to the converter's value.
- R3: A command whose channel field is 63 is never sent to the converter, and it returns its queue to idle. A queue that finishes table entry 63 also returns to idle and does not wrap around.
- R4: A command with its pause bit (bit 6) set is converted, and then its queue goes to paused (code 4). The next trigger for that queue resumes it at the following entry.
- R5: A queue 2 trigger that arrives while queue 1 is active, or in the same cycle as a queue 1 trigger, puts queue 2 in pending (code 2). Queue 2 starts at its start pointer once queue 1 is idle or paused.
- R6: The queue 2 overrun flag is set by a queue 2 trigger that arrives while queue 2 is pending, suspended or active. The queue 1 overrun flag is set by a queue 1 trigger that arrives while queue 1 is active. Each flag stays set until its clear input is pulsed. If a set and a clear occur in the same cycle, the set wins.
- R7: A queue 1 trigger that arrives while queue 2 has a request or conversion outstanding raises `conv_abort` in that same cycle. Any handshake or result in that cycle is void. Queue 2 becomes suspended (code 3), and the aborted command writes no result.
- R8: When queue 1 goes idle or paused, a suspended queue 2 resumes by converting the aborted command again.
- R9: Only one conversion is ever outstanding. A request that is not accepted keeps `conv_valid` high and `conv_chan` unchanged until `conv_ready` or `conv_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q1_trig | input | 1 | Queue 1 trigger pulse |
| q2_trig | input | 1 | Queue 2 trigger pulse |
| q1_start | input | 6 | Queue 1 start index |
| q2_start | input | 6 | Queue 2 start index |
| q1_ovr_clr | input | 1 | Clears the queue 1 overrun flag |
| q2_ovr_clr | input | 1 | Clears the queue 2 overrun flag |
| tbl_addr | output | 6 | Command table read index |
| tbl_word | input | 7 | Command word at `tbl_addr`: {pause, channel} |
| conv_valid | output | 1 | Conversion request valid |
| conv_ready | input | 1 | Converter accepts the request |
| conv_chan | output | 6 | Channel of the requested conversion |
| conv_abort | output | 1 | Cancels the outstanding queue 2 conversion |
| res_valid | input | 1 | Converter result pulse |
| res_data_in | input | 10 | Converter result value |
| res_wr | output | 1 | Result slot write strobe |
| res_idx | output | 6 | Result slot index |
| res_data | output | 10 | Result value to store |
| q1_status | output | 3 | Queue 1 status code |
| q2_status | output | 3 | Queue 2 status code |
| q1_ovr | output | 1 | Queue 1 overrun flag |
| q2_ovr | output | 1 | Queue 2 overrun flag |

## Verification
The bench lets queue 1 interrupt a queue 2 conversion that is already in flight. A design that advanced the queue 2 pointer on abort would skip the aborted command. A design that still honoured the dying result would write a stray slot. The bench fires both triggers in the same cycle and repeats triggers on busy queues, which catches schedulers that let queue 2 start first or that miss overruns. It also walks a queue off table entry 63, where a wrapping pointer would restart at entry 0. A stalled `conv_ready` exposes requests that drop or change their channel before acceptance.

// File: rtl/dualq_pkg.sv
package dualq_pkg;
  typedef enum logic [2:0] {
    QS_IDLE    = 3'd0,
    QS_ACTIVE  = 3'd1,
    QS_PENDING = 3'd2,
    QS_SUSP    = 3'd3,
    QS_PAUSED  = 3'd4
  } qstate_e;

  typedef enum logic [1:0] {
    EN_IDLE = 2'd0,
    EN_REQ  = 2'd1,
    EN_WAIT = 2'd2
  } eng_e;
endpackage

// File: rtl/dualq_queue.sv
module dualq_queue
  import dualq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             hold,      // a higher-priority queue claims the converter
  input  logic             preempt,   // suspend if active
  input  logic [IDX_W-1:0] start_ptr,
  input  logic             cmd_done,
  input  logic             cmd_pause,
  input  logic             cmd_last,
  input  logic             eoq_hit,
  input  logic             ovr_clr,
  output qstate_e          state,
  output logic [IDX_W-1:0] ptr,
  output logic             ovr
);
  qstate_e          st_n;
  logic [IDX_W-1:0] ptr_n;
  logic             ovr_set;

  always_comb begin
    st_n    = state;
    ptr_n   = ptr;
    ovr_set = 1'b0;
    case (state)
      QS_IDLE: begin
        if (trig) begin
          st_n  = hold ? QS_PENDING : QS_ACTIVE;
          ptr_n = start_ptr;
        end
      end
      QS_PAUSED: begin
        if (trig) st_n = hold ? QS_PENDING : QS_ACTIVE;
      end
      QS_ACTIVE: begin
        ovr_set = trig;
        if (preempt) begin
          st_n = QS_SUSP;                 // pointer kept: aborted command reruns
        end else if (eoq_hit) begin
          st_n = QS_IDLE;
        end else if (cmd_done) begin
          if (cmd_last) begin
            st_n = QS_IDLE;
          end else begin
            ptr_n = ptr + IDX_W'(1);
            if (cmd_pause) st_n = QS_PAUSED;
          end
        end
      end
      QS_PENDING, QS_SUSP: begin
        ovr_set = trig;
        if (!hold) st_n = QS_ACTIVE;
      end
      default: st_n = QS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= QS_IDLE;
      ptr   <= '0;
      ovr   <= 1'b0;
    end else begin
      state <= st_n;
      ptr   <= ptr_n;
      if (ovr_set)      ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/dualq_engine.sv
module dualq_engine
  import dualq_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CH_W  = 6,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q1_go,
  input  logic             q2_go,
  input  logic             q1_trig,
  input  logic [IDX_W-1:0] ptr1,
  input  logic [IDX_W-1:0] ptr2,
  output logic [IDX_W-1:0] tbl_addr,
  input  logic [CH_W:0]    tbl_word,
  output logic             conv_valid,
  input  logic             conv_ready,
  output logic [CH_W-1:0]  conv_chan,
  output logic             conv_abort,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data_in,
  output logic             res_wr,
  output logic [IDX_W-1:0] res_idx,
  output logic [RES_W-1:0] res_data,
  output logic             done1,
  output logic             done2,
  output logic             eoq1,
  output logic             eoq2,
  output logic             cmd_pause,
  output logic             cmd_last
);
  localparam logic [CH_W-1:0]  EOQ_CODE = '1;
  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  eng_e             est;
  logic             own2;
  logic [IDX_W-1:0] idx_r;
  logic [CH_W-1:0]  chan_r;
  logic             pause_r;
  logic             sel1, sel2, word_eoq, finish;

  assign tbl_addr   = q1_go ? ptr1 : ptr2;
  assign word_eoq   = (tbl_word[CH_W-1:0] == EOQ_CODE);
  assign sel1       = (est == EN_IDLE) && q1_go;
  assign sel2       = (est == EN_IDLE) && !q1_go && q2_go && !q1_trig;
  assign eoq1       = sel1 && word_eoq;
  assign eoq2       = sel2 && word_eoq;
  assign conv_abort = q1_trig && own2 && (est != EN_IDLE);
  assign conv_valid = (est == EN_REQ);
  assign conv_chan  = chan_r;
  assign finish     = (est == EN_WAIT) && res_valid && !conv_abort;
  assign res_wr     = finish;
  assign res_idx    = idx_r;
  assign res_data   = res_data_in;
  assign done1      = finish && !own2;
  assign done2      = finish && own2;
  assign cmd_pause  = pause_r;
  assign cmd_last   = (idx_r == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est     <= EN_IDLE;
      own2    <= 1'b0;
      idx_r   <= '0;
      chan_r  <= '0;
      pause_r <= 1'b0;
    end else begin
      case (est)
        EN_IDLE: begin
          if ((sel1 || sel2) && !word_eoq) begin
            est     <= EN_REQ;
            own2    <= sel2;
            idx_r   <= tbl_addr;
            chan_r  <= tbl_word[CH_W-1:0];
            pause_r <= tbl_word[CH_W];
          end
        end
        EN_REQ: begin
          if (conv_abort)      est <= EN_IDLE;
          else if (conv_ready) est <= EN_WAIT;
        end
        EN_WAIT: begin
          if (conv_abort || finish) est <= EN_IDLE;
        end
        default: est <= EN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dualq_sched.sv
module dualq_sched
  import dualq_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CH_W  = 6,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q1_trig,
  input  logic             q2_trig,
  input  logic [IDX_W-1:0] q1_start,
  input  logic [IDX_W-1:0] q2_start,
  input  logic             q1_ovr_clr,
  input  logic             q2_ovr_clr,
  output logic [IDX_W-1:0] tbl_addr,
  input  logic [CH_W:0]    tbl_word,
  output logic             conv_valid,
  input  logic             conv_ready,
  output logic [CH_W-1:0]  conv_chan,
  output logic             conv_abort,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data_in,
  output logic             res_wr,
  output logic [IDX_W-1:0] res_idx,
  output logic [RES_W-1:0] res_data,
  output logic [2:0]       q1_status,
  output logic [2:0]       q2_status,
  output logic             q1_ovr,
  output logic             q2_ovr
);
  qstate_e          st1, st2;
  logic [IDX_W-1:0] ptr1, ptr2;
  logic             done1, done2, eoq1, eoq2, cmd_pause, cmd_last;
  logic             q1_claim;

  assign q1_claim  = (st1 == QS_ACTIVE) || q1_trig;
  assign q1_status = st1;
  assign q2_status = st2;

  dualq_queue #(.IDX_W(IDX_W)) u_q1 (
    .clk, .rst_n, .trig(q1_trig), .hold(1'b0), .preempt(1'b0),
    .start_ptr(q1_start), .cmd_done(done1), .cmd_pause, .cmd_last,
    .eoq_hit(eoq1), .ovr_clr(q1_ovr_clr), .state(st1), .ptr(ptr1), .ovr(q1_ovr)
  );

  dualq_queue #(.IDX_W(IDX_W)) u_q2 (
    .clk, .rst_n, .trig(q2_trig), .hold(q1_claim), .preempt(q1_trig),
    .start_ptr(q2_start), .cmd_done(done2), .cmd_pause, .cmd_last,
    .eoq_hit(eoq2), .ovr_clr(q2_ovr_clr), .state(st2), .ptr(ptr2), .ovr(q2_ovr)
  );

  dualq_engine #(.IDX_W(IDX_W), .CH_W(CH_W), .RES_W(RES_W)) u_eng (
    .clk, .rst_n,
    .q1_go(st1 == QS_ACTIVE), .q2_go(st2 == QS_ACTIVE), .q1_trig,
    .ptr1, .ptr2, .tbl_addr, .tbl_word,
    .conv_valid, .conv_ready, .conv_chan, .conv_abort,
    .res_valid, .res_data_in, .res_wr, .res_idx, .res_data,
    .done1, .done2, .eoq1, .eoq2, .cmd_pause, .cmd_last
  );
endmodule

// File: rtl/dualq_sched_sva.sv
module dualq_sched_sva #(
  parameter int IDX_W = 6,
  parameter int CH_W  = 6,
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             q1_trig,
  input logic             q2_ovr_clr,
  input logic             conv_valid,
  input logic             conv_ready,
  input logic [CH_W-1:0]  conv_chan,
  input logic             conv_abort,
  input logic             res_valid,
  input logic             res_wr,
  input logic [2:0]       q1_status,
  input logic [2:0]       q2_status,
  input logic             q2_ovr
);
  a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid && !conv_ready && !conv_abort |=> conv_valid && $stable(conv_chan));

  a_r3_no_marker_issued: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |-> conv_chan != {CH_W{1'b1}});

  a_r7_abort_from_q1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> q1_trig);

  a_r7_abort_suspends: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |=> q2_status == 3'd3);

  a_r5_single_active: assert property (@(posedge clk) disable iff (!rst_n)
    !(q1_status == 3'd1 && q2_status == 3'd1));

  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    q2_ovr && !q2_ovr_clr |=> q2_ovr);

  a_r2_write_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |-> res_valid);
endmodule

bind dualq_sched dualq_sched_sva #(.IDX_W(IDX_W), .CH_W(CH_W), .RES_W(RES_W)) u_sva (.*);

// File: tb/dualq_sched_test.sv
module dualq_sched_test;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       q1_trig = 0, q2_trig = 0, q1_ovr_clr = 0, q2_ovr_clr = 0;
  logic [5:0] q1_start = 0, q2_start = 0;
  logic [5:0] tbl_addr;
  logic [6:0] tbl_word;
  logic       conv_valid, conv_ready = 1'b1, conv_abort;
  logic [5:0] conv_chan;
  logic       res_valid;
  logic [9:0] res_data_in;
  logic       res_wr;
  logic [5:0] res_idx;
  logic [9:0] res_data;
  logic [2:0] q1_status, q2_status;
  logic       q1_ovr, q2_ovr;

  logic [6:0] tbl [64];
  assign tbl_word = tbl[tbl_addr];

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  dualq_sched uut (.*);

  // converter model: result LAT+1 cycles after acceptance, value {4'hA, chan}
  logic       busy;
  int         cnt;
  logic [5:0] cchan;
  always @(posedge clk) begin
    res_valid <= 1'b0;
    if (!rst_n) begin
      busy <= 1'b0; cnt <= 0; cchan <= 0; res_data_in <= 0;
    end else if (conv_abort) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (cnt == 0) begin
        res_valid <= 1'b1; res_data_in <= {4'hA, cchan}; busy <= 1'b0;
      end else cnt <= cnt - 1;
    end else if (conv_valid && conv_ready) begin
      busy <= 1'b1; cnt <= LAT; cchan <= conv_chan;
    end
  end

  int log_idx [64];
  int log_dat [64];
  int n_wr = 0;
  int n_abort = 0;
  always @(posedge clk) begin
    if (rst_n && res_wr && n_wr < 64) begin
      log_idx[n_wr] <= int'(res_idx);
      log_dat[n_wr] <= int'(res_data);
      n_wr <= n_wr + 1;
    end
    if (rst_n && conv_abort) n_abort <= n_abort + 1;
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_wr(string tag, int pos, int exp_idx);
    chk({tag, " slot index"}, log_idx[pos], exp_idx);
    chk({tag, " slot data"}, log_dat[pos], 640 + (exp_idx % 40));
  endtask

  task automatic fill();
    for (int i = 0; i < 64; i++) tbl[i] = {1'b0, 6'(i % 40)};
  endtask

  task automatic fire(bit a, bit b);
    @(negedge clk); q1_trig = a; q2_trig = b;
    @(negedge clk); q1_trig = 0; q2_trig = 0;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 q1 status", int'(q1_status), 0);
    chk("R1 q2 status", int'(q2_status), 0);
    chk("R1 conv_valid", int'(conv_valid), 0);
    chk("R1 overrun flags", int'({q1_ovr, q2_ovr}), 0);
    chk("R1 abort/write", int'({conv_abort, res_wr}), 0);
  endtask

  task automatic t_single_stall();
    int base = n_wr;
    fill(); tbl[3] = 7'd63; q1_start = 0; conv_ready = 0;
    fire(1, 0);
    chk("R2 q1 active", int'(q1_status), 1);
    idle(3);
    chk("R9 request raised", int'(conv_valid), 1);
    chk("R9 request channel", int'(conv_chan), 0);
    idle(4);
    chk("R9 request still held", int'(conv_valid), 1);
    chk("R9 channel stable", int'(conv_chan), 0);
    conv_ready = 1;
    idle(60);
    chk("R2 write count", n_wr - base, 3);
    for (int k = 0; k < 3; k++) chk_wr("R2", base + k, k);
    chk("R3 marker ends q1", int'(q1_status), 0);
  endtask

  task automatic t_pause();
    int base = n_wr;
    fill(); tbl[11] = {1'b1, 6'd11}; tbl[13] = 7'd63; q1_start = 10;
    fire(1, 0); idle(50);
    chk("R4 writes before pause", n_wr - base, 2);
    chk_wr("R4", base, 10);
    chk_wr("R4", base + 1, 11);
    chk("R4 paused code", int'(q1_status), 4);
    fire(1, 0); idle(50);
    chk("R4 writes after resume", n_wr - base, 3);
    chk_wr("R4 resume", base + 2, 12);
    chk("R4 idle at marker", int'(q1_status), 0);
  endtask

  task automatic t_pending();
    int base = n_wr;
    int exp [6] = '{0, 1, 2, 20, 21, 22};
    fill(); tbl[3] = 7'd63; tbl[23] = 7'd63; q1_start = 0; q2_start = 20;
    fire(1, 0);
    fire(0, 1);
    chk("R5 q2 pending", int'(q2_status), 2);
    chk("R6 no overrun on first", int'(q2_ovr), 0);
    fire(0, 1);
    chk("R6 q2 overrun while pending", int'(q2_ovr), 1);
    idle(150);
    chk("R5 write count", n_wr - base, 6);
    for (int k = 0; k < 6; k++) chk_wr("R5 order", base + k, exp[k]);
    chk("R5 q2 done", int'(q2_status), 0);
    chk("R6 q2 overrun sticky", int'(q2_ovr), 1);
    @(negedge clk); q2_ovr_clr = 1;
    @(negedge clk); q2_ovr_clr = 0;
    chk("R6 q2 overrun cleared", int'(q2_ovr), 0);
  endtask

  task automatic t_preempt();
    int base = n_wr;
    int ab0 = n_abort;
    int exp [6] = '{20, 0, 1, 2, 21, 22};
    fill(); tbl[3] = 7'd63; tbl[23] = 7'd63; q1_start = 0; q2_start = 20;
    fire(0, 1);
    while (!(n_wr == base + 1 && busy)) @(negedge clk);
    q1_trig = 1;
    #1;
    chk("R7 abort raised", int'(conv_abort), 1);
    @(negedge clk); q1_trig = 0;
    chk("R7 q2 suspended", int'(q2_status), 3);
    chk("R7 q1 active", int'(q1_status), 1);
    fire(0, 1);
    chk("R6 overrun while suspended", int'(q2_ovr), 1);
    idle(200);
    chk("R8 write count", n_wr - base, 6);
    for (int k = 0; k < 6; k++) chk_wr("R8 order", base + k, exp[k]);
    chk("R7 single abort", n_abort - ab0, 1);
    @(negedge clk); q2_ovr_clr = 1;
    @(negedge clk); q2_ovr_clr = 0;
  endtask

  task automatic t_table_end();
    int base = n_wr;
    fill(); q1_start = 61;
    fire(1, 0); idle(80);
    chk("R3 writes to end", n_wr - base, 3);
    for (int k = 0; k < 3; k++) chk_wr("R3 end", base + k, 61 + k);
    chk("R3 idle after 63", int'(q1_status), 0);
  endtask

  task automatic t_same_cycle();
    int base = n_wr;
    int exp [6] = '{0, 1, 2, 20, 21, 22};
    fill(); tbl[3] = 7'd63; tbl[23] = 7'd63; q1_start = 0; q2_start = 20;
    fire(1, 1);
    chk("R5 same cycle q1", int'(q1_status), 1);
    chk("R5 same cycle q2", int'(q2_status), 2);
    idle(150);
    chk("R5 same cycle count", n_wr - base, 6);
    for (int k = 0; k < 6; k++) chk_wr("R5 same cycle", base + k, exp[k]);
  endtask

  task automatic t_q1_overrun();
    fill(); tbl[3] = 7'd63; q1_start = 0;
    fire(1, 0);
    chk("R6 q1 no overrun", int'(q1_ovr), 0);
    @(negedge clk); q1_trig = 1; q1_ovr_clr = 1;
    @(negedge clk); q1_trig = 0; q1_ovr_clr = 0;
    chk("R6 set beats clear", int'(q1_ovr), 1);
    idle(60);
    chk("R6 q1 overrun sticky", int'(q1_ovr), 1);
    @(negedge clk); q1_ovr_clr = 1;
    @(negedge clk); q1_ovr_clr = 0;
    chk("R6 q1 overrun cleared", int'(q1_ovr), 0);
  endtask

  initial begin
    fill();
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_single_stall();
    t_pause();
    t_pending();
    t_preempt();
    t_table_end();
    t_same_cycle();
    t_q1_overrun();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule